// File: doc/BRIEF.md
# Nine-Level Noise-Shaping Modulator with Element Rotation

This block turns a slow stream of signed PCM samples into a fast stream of nine-level codes for a DAC built from eight equal unit elements. Each incoming sample is held for a fixed number of modulator ticks, which by default is 25. This count is the ratio between a 40 kHz-class input and a 1 MHz modulator rate. A second-order error-feedback loop shapes the quantization noise out of the signal band. A nine-level quantizer then picks how many unit elements to switch on.

A data-weighted rotation decides which elements carry each code. The run of enabled elements starts where the previous run ended. Over time every element is used equally, so element mismatch becomes shaped noise rather than distortion. The host supplies a sample and a one-cycle tick strobe at the modulator rate. It receives the level and the element-enable vector, and both are registered on each tick.

Top module: `sdm_dem_mod`

## Requirements
- R1: While rst_n is low, and after it is released until the first tick, level reads 0 and elem_en reads all zeros. The held sample, both stored errors and the rotation pointer reset to zero.
- R2: level and elem_en change only on a rising clock edge where tick is 1. Both are registered, so they are valid from the cycle after that edge.
- R3: On the first tick after reset, and then on every HOLD-th tick, the block captures sample_in. The captured value feeds the loop from the next tick onward. Changes to sample_in on any other tick have no effect.
- R4: On each tick the loop forms v = x - 2*e1 + e2, where x is the held sample and e1 and e2 are the last two stored errors. With Q = 2^(IN_W-1)/(NEL/2), the output is level = clamp(floor((v + Q/2)/Q) + NEL/2, 0, NEL). Level k stands for the value (k - NEL/2)*Q and is carried as an unsigned code on level.
- R5: After each tick the new error is e = (level - NEL/2)*Q - v, saturated to the range [-Q, +Q]. That error becomes e1, and the previous e1 becomes e2.
- R6: elem_en has exactly level bits set.
- R7: Bit i of elem_en is set when ((i - p) mod NEL) < level, where p is the rotation pointer. p starts at 0 and advances by level mod NEL after each tick.
- R8: Over any run that starts at reset, the numbers of ticks each element has been enabled differ by at most one.
- R9: With sample_in held at 0 from reset, the level is 4 on every tick, so its average is exactly the midscale code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe at the modulator rate |
| sample_in | input | IN_W | Signed PCM input sample |
| level | output | LVL_W | Quantizer code, 0 to NEL |
| elem_en | output | NEL | Unit-element enables after rotation |

## Verification
Every result appears one clock after the edge where tick is high. The bench raises tick at a falling edge and lowers it at the next falling edge. It compares level and elem_en at that point against its own arithmetic model, which has stepped the loop, the hold counter and the pointer exactly once. Two clocks later, with no tick, it checks the same outputs again to confirm they held. The model captures a new sample on the same tick as the design does, and the captured value takes effect one tick later. Because of this, the sweep changes sample_in on every tick without breaking the hold rule.

// File: rtl/sdm_dem_mod.sv
module sdm_dem_mod #(
  parameter int IN_W = 16,
  parameter int HOLD = 25,
  parameter int NEL  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic signed [IN_W-1:0]       sample_in,
  output logic [$clog2(NEL+1)-1:0]     level,
  output logic [NEL-1:0]               elem_en
);
  localparam int LVL_W = $clog2(NEL + 1);
  localparam int PTR_W = $clog2(NEL);
  localparam int CNT_W = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam int W     = IN_W + 3;
  localparam int QSH   = IN_W - 1 - $clog2(NEL / 2);
  localparam logic signed [W-1:0] QP   = W'(1) <<< QSH;
  localparam logic signed [W-1:0] QN   = -QP;
  localparam logic signed [W-1:0] HALF = QP >>> 1;
  localparam logic signed [W-1:0] MID  = W'(NEL / 2);
  localparam logic signed [W-1:0] TOP  = W'(NEL);

  logic [CNT_W-1:0]        hold_cnt;
  logic signed [IN_W-1:0]  x_q;
  logic signed [W-1:0]     e1, e2;
  logic [PTR_W-1:0]        ptr;

  logic signed [W-1:0]     v, r, kraw, y, e_raw, e_sat;
  logic [LVL_W-1:0]        k;
  logic [NEL-1:0]          pattern;

  assign v     = W'(x_q) - (e1 <<< 1) + e2;
  assign r     = (v + HALF) >>> QSH;
  assign kraw  = r + MID;
  assign k     = (kraw < 0) ? '0 : (kraw > TOP) ? LVL_W'(NEL) : LVL_W'(kraw);
  assign y     = ($signed({{(W-LVL_W){1'b0}}, k}) - MID) <<< QSH;
  assign e_raw = y - v;
  assign e_sat = (e_raw > QP) ? QP : (e_raw < QN) ? QN : e_raw;

  for (genvar i = 0; i < NEL; i++) begin : g_elem
    logic [PTR_W-1:0] rel;
    assign rel        = PTR_W'(i) - ptr;
    assign pattern[i] = {{(LVL_W-PTR_W){1'b0}}, rel} < k;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      x_q      <= '0;
    end else if (tick) begin
      if (hold_cnt == '0) begin
        x_q      <= sample_in;
        hold_cnt <= CNT_W'(HOLD - 1);
      end else begin
        hold_cnt <= hold_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e1      <= '0;
      e2      <= '0;
      ptr     <= '0;
      level   <= '0;
      elem_en <= '0;
    end else if (tick) begin
      e2      <= e1;
      e1      <= e_sat;
      ptr     <= ptr + k[PTR_W-1:0];
      level   <= k;
      elem_en <= pattern;
    end
  end
endmodule

// File: rtl/sdm_dem_mod_chk.sv
module sdm_dem_mod_chk #(
  parameter int IN_W  = 16,
  parameter int NEL   = 8,
  parameter int LVL_W = 4,
  parameter int PTR_W = 3,
  parameter int W     = 19
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic [LVL_W-1:0]    level,
  input logic [NEL-1:0]      elem_en,
  input logic [PTR_W-1:0]    ptr,
  input logic signed [W-1:0] e1
);
  localparam int QSH = IN_W - 1 - $clog2(NEL / 2);
  localparam logic signed [W-1:0] QP = W'(1) <<< QSH;

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(NEL)); // R4
  AST_THERM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(elem_en) == int'(level)); // R6
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(level) && $stable(elem_en)); // R2
  AST_RUN_START: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (level == '0) || elem_en[$past(ptr)]); // R7
  AST_RUN_BEFORE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (level == LVL_W'(NEL)) || !elem_en[PTR_W'($past(ptr) - 1'b1)]); // R7
  AST_ERR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (e1 <= QP) && (e1 >= -QP)); // R5
endmodule

bind sdm_dem_mod sdm_dem_mod_chk #(
  .IN_W(IN_W), .NEL(NEL), .LVL_W(LVL_W), .PTR_W(PTR_W), .W(W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .level(level),
  .elem_en(elem_en), .ptr(ptr), .e1(e1)
);

// File: tb/sdm_dem_mod_tb_top.sv
module sdm_dem_mod_tb_top;
  localparam int IN_W = 8;
  localparam int HOLD = 25;
  localparam int NEL  = 8;
  localparam int LVL_W = 4;
  localparam int Q = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic signed [IN_W-1:0] sample_in = '0;
  logic [LVL_W-1:0] level;
  logic [NEL-1:0] elem_en;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_cnt, m_x, m_e1, m_e2, m_ptr, exp_k;
  logic [NEL-1:0] exp_en;
  int use_cnt [NEL];
  int lvl_sum;

  always #10 clk = ~clk;

  sdm_dem_mod #(.IN_W(IN_W), .HOLD(HOLD), .NEL(NEL)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sample_in(sample_in),
    .level(level), .elem_en(elem_en));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step(input int smp);
    int v, k, e;
    v = m_x - 2 * m_e1 + m_e2;
    k = ((v + Q / 2) >>> 5) + 4;
    if (k < 0) k = 0;
    if (k > NEL) k = NEL;
    e = (k - 4) * Q - v;
    if (e > Q) e = Q;
    if (e < -Q) e = -Q;
    for (int i = 0; i < NEL; i++) exp_en[i] = (((i - m_ptr) & 7) < k);
    exp_k = k;
    m_ptr = (m_ptr + k) & 7;
    m_e2 = m_e1;
    m_e1 = e;
    if (m_cnt == 0) begin
      m_x = smp;
      m_cnt = HOLD - 1;
    end else m_cnt--;
  endtask

  task automatic do_tick(input int smp);
    @(negedge clk);
    sample_in = IN_W'(smp);
    tick = 1'b1;
    model_step(smp);
    @(negedge clk);
    tick = 1'b0;
    chk(int'(level) == exp_k, "R3 R4 R5 level", int'(level), exp_k);
    chk(elem_en == exp_en, "R7 elem_en", int'(elem_en), int'(exp_en));
    chk($countones(elem_en) == int'(level), "R6 popcount", $countones(elem_en), int'(level));
    for (int i = 0; i < NEL; i++) use_cnt[i] += int'(elem_en[i]);
    lvl_sum += int'(level);
    sample_in = IN_W'(smp ^ 8'h5a);
    @(negedge clk);
    @(negedge clk);
    chk(int'(level) == exp_k && elem_en == exp_en, "R2 hold between ticks", int'(level), exp_k);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    m_cnt = 0; m_x = 0; m_e1 = 0; m_e2 = 0; m_ptr = 0;
    lvl_sum = 0;
    for (int i = 0; i < NEL; i++) use_cnt[i] = 0;
    repeat (3) @(negedge clk);
    chk(level == '0 && elem_en == '0, "R1 reset", int'(level), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(level == '0 && elem_en == '0, "R1 after release", int'(elem_en), 0);

    for (int t = 0; t < 100; t++) do_tick(0);
    chk(lvl_sum == 400, "R9 zero-input average", lvl_sum, 400);

    for (int t = 0; t < 50; t++) do_tick(-128);
    for (int t = 0; t < 50; t++) do_tick(127);
    for (int t = 0; t < 100; t++) do_tick((t % 2) ? 127 : -128);
    for (int t = 0; t < 256 * HOLD; t++) do_tick(((t * 37 + 11) & 255) - 128);

    begin
      int mx, mn;
      mx = use_cnt[0]; mn = use_cnt[0];
      for (int i = 1; i < NEL; i++) begin
        if (use_cnt[i] > mx) mx = use_cnt[i];
        if (use_cnt[i] < mn) mn = use_cnt[i];
      end
      chk(mx - mn <= 1, "R8 element balance", mx - mn, 1);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule